// File: doc/BRIEF.md
# Dual-Read Operand Store with Mapped I/O

This block is the single data store of a three-operand, multithreaded soft processor. It takes the place of both a register file and a data RAM: instructions name their operands by address, and there are no load or store operations. Two identical storage copies are kept. Each copy is read through its own address port, so both source operands of an instruction are fetched in the same cycle. Every result write goes to both copies at once, which keeps them identical.

A contiguous window of `IO_COUNT` addresses starting at `IO_BASE` is not backed by storage. Reading an address in the window returns one word of the input port bundle. Writing an address in the window loads one word of the output port bundle and pulses a matching strobe. Every path through the block is registered before and after the storage arrays, so reads and writes each take exactly two register stages. As a result, no array output drives another array directly.

Top module: `opstore_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, both read data outputs, all of `io_out` and all of `io_wstb` are zero after that edge.
- R2: An address presented on a read port during cycle n produces its data on that port's output after the second rising edge that follows, whatever address is presented in cycle n+1.
- R3: The two read ports take independent addresses, and both return correct data in the same cycle.
- R4: A write is stored in both copies, so reads of the same address on port A and on port B always return equal data.
- R5: When `wr_en` is high in cycle n for an address outside the window, a read of that address presented in cycle n+1 or later returns `wr_data`.
- R6: When a read and a write to the same address are presented in the same cycle, the read returns the value stored before that write.
- R7: When `wr_en` is low, `wr_addr` and `wr_data` change no stored word.
- R8: For an address `IO_BASE+k` with k below `IO_COUNT`, a read returns `io_in[k*WORD_W +: WORD_W]` as it was during the cycle in which the address was presented.
- R9: A write to `IO_BASE+k` in cycle n sets `io_out[k*WORD_W +: WORD_W]` to `wr_data`. It also raises `io_wstb[k]`, and only that bit, for exactly one cycle after the second rising edge.
- R10: A write into the window leaves every storage address outside the window unchanged, including the two addresses that border it.
- R11: Each `io_out` word keeps its value in every cycle in which its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_a_addr | input | ADDR_W | Read address of copy A (first source operand) |
| rd_b_addr | input | ADDR_W | Read address of copy B (second source operand) |
| rd_a_data | output | WORD_W | Operand from copy A, two cycles after its address |
| rd_b_data | output | WORD_W | Operand from copy B, two cycles after its address |
| wr_en | input | 1 | Result write request |
| wr_addr | input | ADDR_W | Result write address |
| wr_data | input | WORD_W | Result value |
| io_in | input | IO_COUNT*WORD_W | Input words returned for window reads, word k at bits k*WORD_W |
| io_out | output | IO_COUNT*WORD_W | Output words loaded by window writes |
| io_wstb | output | IO_COUNT | One-cycle write strobe per output word |

## Verification
The assertions check four things on every cycle after reset: that the A and B outputs agree whenever both ports read the same address, that window reads return the input word sampled two cycles earlier, that at most one strobe is high and that it comes from a matching window write with the written value, and that each output word holds while its strobe is low. Other behaviour appears only over a whole scenario, so only the bench's sweeps can show it. This includes whether stored data survives, whether the old value is returned on a same-cycle collision, whether a disabled write is ignored, and whether a window write leaves the bordering storage words untouched. The bench covers these with a full sweep of a small 32-word configuration whose window sits in the middle of the address space.

// File: rtl/opstore_pkg.sv
// Package: shared helpers for the operand store.
// Assumes addresses fit in 32 bits.
package opstore_pkg;

    // True when addr lies in the I/O window [base, base+count).
    function automatic logic in_window(input logic [31:0] addr,
                                       input int unsigned base,
                                       input int unsigned count);
        return (addr >= base) && (addr < base + count);
    endfunction

endpackage

// File: rtl/opstore_wr_stage.sv
// Write input stage: registers the result write and decodes it into a
// storage write or a one-hot I/O port write.
// Assumes the window lies inside the address range.
module opstore_wr_stage #(
    parameter int unsigned WORD_W   = 36,
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned IO_BASE  = 1020,
    parameter int unsigned IO_COUNT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [WORD_W-1:0]   wr_data,
    output logic                ram_we,
    output logic [ADDR_W-1:0]   ram_addr,
    output logic [WORD_W-1:0]   wdata,
    output logic [IO_COUNT-1:0] io_sel
);
    import opstore_pkg::*;

    logic                hit;
    logic [IO_COUNT-1:0] sel_d;

    // Decode the incoming write address against the window.
    always_comb begin
        hit = in_window(32'(wr_addr), IO_BASE, IO_COUNT);
        for (int unsigned k = 0; k < IO_COUNT; k++) begin
            sel_d[k] = wr_en && (32'(wr_addr) == IO_BASE + k);
        end
    end

    // Register the decoded write ahead of the arrays and port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we   <= 1'b0;
            ram_addr <= '0;
            wdata    <= '0;
            io_sel   <= '0;
        end else begin
            ram_we   <= wr_en && !hit;
            ram_addr <= wr_addr;
            wdata    <= wr_data;
            io_sel   <= sel_d;
        end
    end
endmodule

// File: rtl/opstore_bank.sv
// One storage copy with its read port: registered address (and I/O word)
// stage, then registered data stage. Writes come from the shared write stage.
// Assumes DEPTH == 2**ADDR_W. Storage is not reset.
module opstore_bank #(
    parameter int unsigned WORD_W   = 36,
    parameter int unsigned DEPTH    = 1024,
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned IO_BASE  = 1020,
    parameter int unsigned IO_COUNT = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic [IO_COUNT*WORD_W-1:0]   io_in,
    input  logic                         ram_we,
    input  logic [ADDR_W-1:0]            ram_addr,
    input  logic [WORD_W-1:0]            wdata,
    output logic [WORD_W-1:0]            rd_data
);
    import opstore_pkg::*;

    logic [WORD_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] addr_q;
    logic              io_hit_q;
    logic [WORD_W-1:0] io_word_q;
    logic [WORD_W-1:0] io_pick;

    // Select the input word addressed by the read address, zero outside.
    always_comb begin
        io_pick = '0;
        for (int unsigned k = 0; k < IO_COUNT; k++) begin
            if (32'(rd_addr) == IO_BASE + k) io_pick = io_in[k*WORD_W +: WORD_W];
        end
    end

    // Address stage: capture address, window flag and input word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            io_hit_q  <= 1'b0;
            io_word_q <= '0;
        end else begin
            addr_q    <= rd_addr;
            io_hit_q  <= in_window(32'(rd_addr), IO_BASE, IO_COUNT);
            io_word_q <= io_pick;
        end
    end

    // Storage write from the registered write stage.
    always_ff @(posedge clk) begin
        if (ram_we) mem[ram_addr] <= wdata;
    end

    // Data stage: registered read, old data on a same-edge write.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= io_hit_q ? io_word_q : mem[addr_q];
    end
endmodule

// File: rtl/opstore_io_out.sv
// Output port registers: loads the selected word and pulses its strobe for
// one cycle. Assumes io_sel is one-hot or zero.
module opstore_io_out #(
    parameter int unsigned WORD_W   = 36,
    parameter int unsigned IO_COUNT = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [IO_COUNT-1:0]          io_sel,
    input  logic [WORD_W-1:0]            wdata,
    output logic [IO_COUNT*WORD_W-1:0]   io_out,
    output logic [IO_COUNT-1:0]          io_wstb
);
    for (genvar k = 0; k < IO_COUNT; k++) begin : g_port
        // Load word k and its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                io_out[k*WORD_W +: WORD_W] <= '0;
                io_wstb[k]                 <= 1'b0;
            end else begin
                io_wstb[k] <= io_sel[k];
                if (io_sel[k]) io_out[k*WORD_W +: WORD_W] <= wdata;
            end
        end
    end
endmodule

// File: rtl/opstore_top.sv
// Operand store: two identical storage copies with a broadcast write, one
// read port each, and an address window mapped to I/O ports.
// Read latency 2, write latency 2. Assumes DEPTH is a power of two and
// IO_BASE + IO_COUNT <= DEPTH.
module opstore_top #(
    parameter int unsigned WORD_W   = 36,
    parameter int unsigned DEPTH    = 1024,
    parameter int unsigned IO_COUNT = 4,
    parameter int unsigned IO_BASE  = DEPTH - IO_COUNT,
    localparam int unsigned ADDR_W  = $clog2(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [ADDR_W-1:0]            rd_a_addr,
    input  logic [ADDR_W-1:0]            rd_b_addr,
    output logic [WORD_W-1:0]            rd_a_data,
    output logic [WORD_W-1:0]            rd_b_data,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [WORD_W-1:0]            wr_data,
    input  logic [IO_COUNT*WORD_W-1:0]   io_in,
    output logic [IO_COUNT*WORD_W-1:0]   io_out,
    output logic [IO_COUNT-1:0]          io_wstb
);
    localparam int unsigned COPIES = 2;

    logic                ram_we;
    logic [ADDR_W-1:0]   ram_addr;
    logic [WORD_W-1:0]   wdata;
    logic [IO_COUNT-1:0] io_sel;
    logic [ADDR_W-1:0]   rd_addr_v [COPIES];
    logic [WORD_W-1:0]   rd_data_v [COPIES];

    // Route the operand addresses and results to the copies.
    always_comb begin
        rd_addr_v[0] = rd_a_addr;
        rd_addr_v[1] = rd_b_addr;
        rd_a_data    = rd_data_v[0];
        rd_b_data    = rd_data_v[1];
    end

    opstore_wr_stage #(
        .WORD_W(WORD_W), .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .IO_COUNT(IO_COUNT)
    ) u_wr (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ram_we(ram_we), .ram_addr(ram_addr),
        .wdata(wdata), .io_sel(io_sel)
    );

    for (genvar c = 0; c < COPIES; c++) begin : g_copy
        opstore_bank #(
            .WORD_W(WORD_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
            .IO_BASE(IO_BASE), .IO_COUNT(IO_COUNT)
        ) u_bank (
            .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr_v[c]), .io_in(io_in),
            .ram_we(ram_we), .ram_addr(ram_addr), .wdata(wdata),
            .rd_data(rd_data_v[c])
        );
    end

    opstore_io_out #(
        .WORD_W(WORD_W), .IO_COUNT(IO_COUNT)
    ) u_io (
        .clk(clk), .rst_n(rst_n), .io_sel(io_sel), .wdata(wdata),
        .io_out(io_out), .io_wstb(io_wstb)
    );
endmodule

// File: rtl/opstore_checker.sv
// Checker for opstore_top, attached by bind. Observes ports only and arms
// three cycles after reset so no $past reaches before reset.
module opstore_checker #(
    parameter int unsigned WORD_W   = 36,
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned IO_BASE  = 1020,
    parameter int unsigned IO_COUNT = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [ADDR_W-1:0]            rd_a_addr,
    input logic [ADDR_W-1:0]            rd_b_addr,
    input logic [WORD_W-1:0]            rd_a_data,
    input logic [WORD_W-1:0]            rd_b_data,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [WORD_W-1:0]            wr_data,
    input logic [IO_COUNT*WORD_W-1:0]   io_in,
    input logic [IO_COUNT*WORD_W-1:0]   io_out,
    input logic [IO_COUNT-1:0]          io_wstb
);
    logic [1:0] since;
    logic       armed;

    // Count cycles since reset, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              since <= '0;
        else if (since != 2'd3)  since <= since + 2'd1;
    end
    assign armed = (since == 2'd3);

    assert_ab_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(rd_a_addr, 2) == $past(rd_b_addr, 2)) |-> (rd_a_data == rd_b_data));

    assert_strobe_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(io_wstb));

    for (genvar k = 0; k < IO_COUNT; k++) begin : g_io
        localparam logic [ADDR_W-1:0] AK = ADDR_W'(IO_BASE + k);

        assert_strobe_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && io_wstb[k]) |-> ($past(wr_en, 2) && $past(wr_addr, 2) == AK
                && io_out[k*WORD_W +: WORD_W] == $past(wr_data, 2)));

        assert_io_read_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(rd_a_addr, 2) == AK) |-> (rd_a_data == $past(io_in[k*WORD_W +: WORD_W], 2)));

        assert_io_read_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && $past(rd_b_addr, 2) == AK) |-> (rd_b_data == $past(io_in[k*WORD_W +: WORD_W], 2)));

        assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
            (armed && !io_wstb[k]) |-> $stable(io_out[k*WORD_W +: WORD_W]));
    end
endmodule

bind opstore_top opstore_checker #(
    .WORD_W(WORD_W), .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .IO_COUNT(IO_COUNT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
    .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .io_in(io_in), .io_out(io_out),
    .io_wstb(io_wstb)
);

// File: tb/opstore_top_test.sv
// Sweep bench for opstore_top on a 32-word, 16-bit configuration whose
// I/O window (addresses 8..11) sits in the middle of the address space.
module opstore_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 16;
    localparam int D    = 32;
    localparam int NIO  = 4;
    localparam int BASE = 8;
    localparam int AW   = 5;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [AW-1:0]     rd_a_addr, rd_b_addr, wr_addr;
    logic [W-1:0]      rd_a_data, rd_b_data, wr_data;
    logic              wr_en;
    logic [NIO*W-1:0]  io_in, io_out;
    logic [NIO-1:0]    io_wstb;

    logic [W-1:0] model [D];
    int  n_checks = 0;
    int  n_fail   = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opstore_top #(.WORD_W(W), .DEPTH(D), .IO_COUNT(NIO), .IO_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .rd_a_addr(rd_a_addr), .rd_b_addr(rd_b_addr),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .io_in(io_in), .io_out(io_out),
        .io_wstb(io_wstb)
    );

    function automatic bit in_win(input int a);
        return a >= BASE && a < BASE + NIO;
    endfunction

    function automatic logic [W-1:0] pattern(input int a, input int salt);
        return W'(a * 16'd409 + salt * 16'd77 + 16'h3c1);
    endfunction

    function automatic logic [W-1:0] expect_rd(input int a);
        return in_win(a) ? io_in[(a-BASE)*W +: W] : model[a];
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [NIO*W-1:0] act,
                         input logic [NIO*W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write1(input int a, input logic [W-1:0] d);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        if (!in_win(a)) model[a] = d;
        tick();
        wr_en = 1'b0;
    endtask

    // Present two addresses, move them after one edge, check after the second.
    task automatic read2(input string req, input int a, input int b);
        logic [W-1:0] ea, eb;
        ea = expect_rd(a);
        eb = expect_rd(b);
        rd_a_addr = AW'(a); rd_b_addr = AW'(b);
        tick();
        rd_a_addr = AW'(a + 13); rd_b_addr = AW'(b + 7);
        tick();
        check(req, (NIO*W)'(rd_a_data), (NIO*W)'(ea));
        check(req, (NIO*W)'(rd_b_data), (NIO*W)'(eb));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NIO*W-1:0] out_before;
        logic [W-1:0]     oldv;
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        rd_a_addr = '0; rd_b_addr = '0;
        for (int k = 0; k < NIO; k++) io_in[k*W +: W] = W'(16'hA0A0 + k * 16'h0111);
        tick(); tick();
        // R1: reset state
        check("R1", (NIO*W)'(rd_a_data), '0);
        check("R1", (NIO*W)'(rd_b_data), '0);
        check("R1", io_out, '0);
        check("R1", (NIO*W)'(io_wstb), '0);
        rst_n = 1'b1;
        tick();

        // Fill every storage address (R4 broadcast, R5 visibility).
        for (int a = 0; a < D; a++) if (!in_win(a)) write1(a, pattern(a, 1));
        tick();

        // R2/R3: independent pairs across the whole space, window included (R8).
        for (int a = 0; a < D; a++) read2("R2 R3 R8", a, D - 1 - a);
        // R4: both copies return the same word for the same address.
        for (int a = 0; a < D; a++) read2("R4", a, a);

        // R8: input word taken in the address cycle, not later.
        rd_a_addr = AW'(BASE + 2); rd_b_addr = AW'(BASE + 1);
        oldv = io_in[2*W +: W];
        tick();
        io_in[2*W +: W] = 16'h1111;
        tick();
        check("R8", (NIO*W)'(rd_a_data), (NIO*W)'(oldv));
        check("R8", (NIO*W)'(rd_b_data), (NIO*W)'(io_in[1*W +: W]));

        // R9/R11: each window port in turn.
        for (int k = 0; k < NIO; k++) begin
            logic [NIO*W-1:0] expo;
            out_before = io_out;
            expo = out_before;
            expo[k*W +: W] = W'(16'h5500 + k);
            write1(BASE + k, W'(16'h5500 + k));
            check("R11", io_out, out_before);
            tick();
            check("R9", io_out, expo);
            check("R9", (NIO*W)'(io_wstb), (NIO*W)'(1 << k));
            tick();
            check("R9", (NIO*W)'(io_wstb), '0);
            check("R11", io_out, expo);
        end
        // R10: storage around and outside the window unchanged.
        for (int a = 0; a < D; a++) read2("R10", a, (a + 5) % D);

        // R6: same-cycle read and write to one address returns old data.
        oldv = model[3];
        wr_en = 1'b1; wr_addr = 5'd3; wr_data = 16'hBEEF;
        rd_a_addr = 5'd3; rd_b_addr = 5'd3;
        model[3] = 16'hBEEF;
        tick();
        wr_en = 1'b0; rd_a_addr = 5'd0; rd_b_addr = 5'd0;
        tick();
        check("R6", (NIO*W)'(rd_a_data), (NIO*W)'(oldv));
        check("R6", (NIO*W)'(rd_b_data), (NIO*W)'(oldv));
        // R5: the read one cycle after the write sees the new value.
        write1(20, 16'h7E57);
        read2("R5", 20, 3);
        // Boundary words either side of the window, written right after each other.
        write1(BASE - 1, 16'hC0DE);
        write1(BASE + NIO, 16'hD00D);
        read2("R5", BASE - 1, BASE + NIO);

        // R7: disabled writes change nothing.
        for (int a = 0; a < D; a++) begin
            wr_en = 1'b0; wr_addr = AW'(a); wr_data = 16'hDEAD;
            tick();
        end
        out_before = io_out;
        for (int a = 0; a < D; a++) read2("R7", a, D - 1 - a);
        check("R7", io_out, out_before);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule